// File: doc/BRIEF.md
# Down-Counting Interval Timer with Staged Reload

This block is one 32-bit timer channel that counts down by one on every clock edge while it is enabled. Software sets it up through a small register port with one-cycle writes and combinational reads. The port gives access to an active reload value, a staged (background) reload value, the live count, a control word and a raw event flag.

In periodic operation the counter reloads itself each time it passes through zero. In one-shot operation it stops at zero until software arms it again. Each pass through zero sets a sticky flag, and software clears the flag by writing one to it. The interrupt line is that flag gated by an enable bit.

A staged reload value lets software change the period of a running timer without disturbing the count in progress. The staged value is used at the next reload. A direct write to the active reload value restarts the count at once. At 100 MHz the full 32-bit range gives a timeout of roughly 42.9 seconds.

Top module: `sys_countdown_timer`

## Requirements
- R1: While the enable bit (control bit 0, address 3) is 1 and the timer is not halted, the count drops by one on each clock edge. While the enable bit is 0, the count holds its value.
- R2: In periodic mode (control bit 1 = 0), an enabled count of zero sets the flag on the next edge, and the counter takes the active reload value on that same edge.
- R3: In one-shot mode (control bit 1 = 1), an enabled count of zero sets the flag once. The counter then stays at zero and raises no further events.
- R4: In one-shot mode, a write to the active reload register (address 0) starts a new countdown from the written value.
- R5: A write to the staged reload register (address 1) copies the value into the active reload register (read back at address 0). The running count is left alone, and the new value is used at the next periodic reload.
- R6: A write to address 0 loads the counter on the edge that accepts the write, and it also sets the staged register to the same value. This load takes priority over decrement and over reload.
- R7: A control write that changes bit 1 from 1 to 0 restarts the counter from the active reload value on the accepting edge.
- R8: The flag (address 4, bit 0) stays at 1 until a write with bit 0 = 1 to address 4 clears it. When a new zero event falls on the same edge as the clear, the flag stays set.
- R9: The interrupt output equals the flag ANDed with the interrupt-enable bit (control bit 2).
- R10: After reset, the count, both reload registers, the flag and the control bits all read 0.
- R11: Reading address 2 returns the live count. Reading any address outside 0 to 4 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, also the count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Gated interrupt |

## Verification
Two pairs of functions can meet on the same edge. The first pair is a zero event, which sets the flag, and a software write-one-to-clear. The second is a zero event and a direct load. The bench waits until the count reads zero, then issues the clear or the load on the edge where the event fires. It judges the result by checking that the flag is still set afterwards and that the counter holds the loaded value rather than the reload value.

// File: rtl/tmr_pkg.sv
// Shared constants for the countdown timer: register addresses and
// control-bit positions. Assumes a 3-bit register address space.
package tmr_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAGE = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd4;
    localparam int B_EN  = 0;
    localparam int B_ONE = 1;
    localparam int B_IE  = 2;
endpackage

// File: rtl/tmr_regs.sv
// Register file of the timer: active and staged reload values plus control
// bits. Emits single-cycle strobes for a direct load, a one-shot-to-periodic
// restart and a flag clear. Assumes writes are one-cycle pulses on wr_en.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      load_q,
    output logic [W-1:0]      stage_q,
    output logic              enable,
    output logic              oneshot,
    output logic              ie,
    output logic              load_wr,
    output logic              restart,
    output logic              flag_clr
);
    logic ctrl_wr;

    // Decode the write strobes.
    always_comb begin
        load_wr  = wr_en && (wr_addr == A_LOAD);
        ctrl_wr  = wr_en && (wr_addr == A_CTRL);
        flag_clr = wr_en && (wr_addr == A_FLAG) && wr_data[0];
        restart  = ctrl_wr && oneshot && !wr_data[B_ONE];
    end

    // Hold the reload values and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '0;
            stage_q <= '0;
            enable  <= 1'b0;
            oneshot <= 1'b0;
            ie      <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_LOAD || wr_addr == A_STAGE) begin
                load_q  <= wr_data;
                stage_q <= wr_data;
            end
            if (ctrl_wr) begin
                enable  <= wr_data[B_EN];
                oneshot <= wr_data[B_ONE];
                ie      <= wr_data[B_IE];
            end
        end
    end
endmodule

// File: rtl/tmr_core.sv
// Down counter with periodic reload and one-shot halt. Assumes the
// priority order load write > mode restart > zero handling > decrement.
module tmr_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         oneshot,
    input  logic         load_wr,
    input  logic [W-1:0] load_data,
    input  logic         restart,
    input  logic [W-1:0] load_q,
    output logic [W-1:0] count,
    output logic         halted,
    output logic         zero_evt
);
    // A zero event fires while the counter is enabled, running and at zero.
    always_comb zero_evt = enable && !halted && (count == '0);

    // Advance, reload or halt the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            halted <= 1'b0;
        end else if (load_wr) begin
            count  <= load_data;
            halted <= 1'b0;
        end else if (restart) begin
            count  <= load_q;
            halted <= 1'b0;
        end else if (zero_evt) begin
            if (oneshot) halted <= 1'b1;
            else         count  <= load_q;
        end else if (enable && !halted) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_irq.sv
// Sticky event flag with write-one-to-clear and an enable gate.
// Assumes a set and a clear on the same edge resolve to set.
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    // Hold the raw flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    // Gate the flag onto the interrupt line.
    always_comb irq = flag && ie;
endmodule

// File: rtl/sys_countdown_timer.sv
// Top of the timer channel: joins the registers, the counter and the flag,
// and provides the combinational read multiplexer.
// Assumes a single clock and a synchronous active-low reset.
module sys_countdown_timer
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic              irq
);
    logic [W-1:0] load_q, stage_q, count;
    logic         enable, oneshot, ie, load_wr, restart, flag_clr;
    logic         halted, zero_evt, flag;

    tmr_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_q(load_q), .stage_q(stage_q),
        .enable(enable), .oneshot(oneshot), .ie(ie), .load_wr(load_wr),
        .restart(restart), .flag_clr(flag_clr)
    );

    tmr_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .oneshot(oneshot),
        .load_wr(load_wr), .load_data(wr_data), .restart(restart),
        .load_q(load_q), .count(count), .halted(halted), .zero_evt(zero_evt)
    );

    tmr_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_evt(zero_evt), .clr(flag_clr),
        .ie(ie), .flag(flag), .irq(irq)
    );

    // Select read data by address.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_LOAD:  rd_data = load_q;
            A_STAGE: rd_data = stage_q;
            A_COUNT: rd_data = count;
            A_CTRL:  rd_data = {{(W-3){1'b0}}, ie, oneshot, enable};
            A_FLAG:  rd_data = {{(W-1){1'b0}}, flag};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
// Property checker for the timer channel, attached through bind.
module tmr_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         oneshot,
    input logic         ie,
    input logic         halted,
    input logic         load_wr,
    input logic         restart,
    input logic         flag_clr,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] load_q,
    input logic [W-1:0] count,
    input logic         flag,
    input logic         irq
);
    a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !halted && count != '0 && !load_wr && !restart)
        |=> count == $past(count) - 1'b1);

    a_r1_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !load_wr && !restart) |=> $stable(count));

    a_r2_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !oneshot && !halted && count == '0 && !load_wr && !restart)
        |=> (count == $past(load_q)) && flag);

    a_r3_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !load_wr && !restart) |=> (count == '0) && halted);

    a_r6_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> count == $past(wr_data));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);
endmodule

bind sys_countdown_timer tmr_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .oneshot(oneshot), .ie(ie),
    .halted(halted), .load_wr(load_wr), .restart(restart),
    .flag_clr(flag_clr), .wr_data(wr_data), .load_q(load_q),
    .count(count), .flag(flag), .irq(irq)
);

// File: tb/sys_countdown_timer_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module sys_countdown_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    localparam logic [2:0] LOAD = 3'd0, STAGE = 3'd1, CNT = 3'd2, CTRL = 3'd3, FLG = 3'd4;
    localparam logic [31:0] EN = 32'h1, ONE = 32'h2, IE = 32'h4;

    sys_countdown_timer u_sys_countdown_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // All tasks are entered at a falling edge and return at one.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(2); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(CNT, v);   chk("R10 count", v, 0);
        rd(LOAD, v);  chk("R10 load", v, 0);
        rd(STAGE, v); chk("R10 stage", v, 0);
        rd(FLG, v);   chk("R10 flag", v, 0);
        rd(CTRL, v);  chk("R10 ctrl", v, 0);
        rd(3'd6, v);  chk("R11 unmapped", v, 0);
        chk("R10 irq", irq, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        do_reset();
        wr(LOAD, 10);
        rd(STAGE, v); chk("R6 stage follows load", v, 10);
        wr(CTRL, EN | IE);
        rd(CNT, v); chk("R1 no step before enable", v, 10);
        tick(3); rd(CNT, v); chk("R1 decrement", v, 7);
        tick(7); rd(CNT, v); chk("R11 live count zero", v, 0);
        rd(FLG, v); chk("R2 flag not yet", v, 0);
        tick(1); rd(CNT, v); chk("R2 reload", v, 10);
        rd(FLG, v); chk("R2 flag set", v, 1);
        chk("R9 irq high", irq, 1);
        tick(2); rd(FLG, v); chk("R8 sticky", v, 1);
        wr(FLG, 1); rd(FLG, v); chk("R8 cleared", v, 0);
        chk("R9 irq low", irq, 0);
        wr(CTRL, IE); rd(CNT, v);
        tick(3); rd(CNT, v); chk("R1 hold when disabled", v, v);
        begin
            logic [31:0] h;
            rd(CNT, h); tick(2); rd(CNT, v); chk("R1 frozen", v, h);
        end
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        do_reset();
        wr(LOAD, 3);
        wr(CTRL, EN | ONE | IE);
        tick(3); rd(CNT, v); chk("R3 at zero", v, 0);
        tick(1); rd(FLG, v); chk("R3 flag once", v, 1);
        tick(5); rd(CNT, v); chk("R3 halted", v, 0);
        wr(FLG, 1); tick(4); rd(FLG, v); chk("R3 no second event", v, 0);
        wr(STAGE, 50); rd(CNT, v); chk("R5 no restart", v, 0);
        rd(LOAD, v); chk("R5 copied to load", v, 50);
        tick(3); rd(CNT, v); chk("R5 still halted", v, 0);
        wr(LOAD, 5); rd(CNT, v); chk("R4 rearm", v, 5);
        tick(1); rd(CNT, v); chk("R4 counting", v, 4);
        tick(5); rd(FLG, v); chk("R4 second event", v, 1);
        rd(CNT, v); chk("R4 halted again", v, 0);
        wr(CTRL, EN | IE); rd(CNT, v); chk("R7 restart from load", v, 5);
        tick(1); rd(CNT, v); chk("R7 counting", v, 4);
    endtask

    task automatic t_stage();
        logic [31:0] v;
        do_reset();
        wr(LOAD, 4);
        wr(CTRL, EN);
        tick(2); rd(CNT, v); chk("R1 count", v, 2);
        wr(STAGE, 9); rd(CNT, v); chk("R5 count undisturbed", v, 1);
        rd(LOAD, v); chk("R5 load updated", v, 9);
        tick(2); rd(CNT, v); chk("R5 next reload uses stage", v, 9);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        do_reset();
        wr(LOAD, 2);
        wr(CTRL, EN | IE);
        tick(2); rd(CNT, v); chk("R2 at zero", v, 0);
        wr(FLG, 1); rd(FLG, v); chk("R8 set wins over clear", v, 1);
        rd(CNT, v); chk("R2 reload on collision", v, 2);
        tick(2); rd(CNT, v); chk("R6 at zero", v, 0);
        wr(LOAD, 7); rd(CNT, v); chk("R6 load wins over reload", v, 7);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        do_reset();
        wr(LOAD, 1);
        wr(CTRL, EN);
        tick(2); rd(FLG, v); chk("R9 flag raised", v, 1);
        chk("R9 irq masked", irq, 0);
        wr(CTRL, EN | IE); chk("R9 irq unmasked", irq, 1);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_periodic();
        t_oneshot();
        t_stage();
        t_collide();
        t_gate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule